// File: doc/BRIEF.md
# Serial Shift-Register Output Controller

This block drives a cascade of up to three external 8-bit serial-in, parallel-out shift registers, such as LED drivers or output expanders. Software sets the output word and the configuration through a small 32-bit register port. It then requests a transfer. The block shifts the enabled bits out on a data line and a shift-clock line, and then pulses a store strobe so that the external registers move the new pattern to their outputs.

Any of the eight lowest output bits can be handed to a hardware status source instead of software. Bits 1:0 can come from a line-modem core, bits 4:2 from a first PHY and bits 7:5 from a second PHY. A rate timer running on the bus clock can start transfers by itself, so that these hardware-owned bits are refreshed without software. Register writes are always accepted in the cycle they are presented, and the port applies no back-pressure. A transfer request made while a transfer is running is held, and it is serviced as soon as that transfer ends.

Top module: `sro_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and ser_clk, ser_data and ser_store are all 0.
- R2: Register readback uses these offsets:
  - Offset 0x00 returns the first PHY mask in [29:27], the edge select in [26], the modem mask in [25:24], the second PHY mask in [17:15] and busy in [0]. The update bit [31] always reads 0.
  - Offset 0x04 returns the timer source in [31:30], the rate code in [24:23] and the group enables in [2:0].
  - Offset 0x08 returns the output word in [23:0].
  - Offsets 0x0C and 0x10 read 0.
- R3: A transfer shifts 8 times the position of the highest set group-enable bit: 8, 16 or 24 bits. With all group enables clear, a request produces no transfer and no strobe.
- R4: Writing 1 to bit 31 at offset 0x00 while the block is idle starts a transfer, and the first bit is on ser_data in the next cycle. Bits go out MSB first, from bit n-1 down to bit 0, and each bit is held for 4 clock cycles. Each output bit b<8 is taken from the hardware input when its mask bit is set, and from the output word otherwise. Bits 1:0 use mask [25:24] and the modem inputs, bits 4:2 use mask [29:27] and the first PHY inputs, and bits 7:5 use mask [17:15] and the second PHY inputs.
- R5: Within each bit, ser_clk holds one level for the first two cycles and the opposite level for the last two. With edge select 0 the sequence is low then high, so data is captured on the rising edge. With edge select 1 it is high then low. While no bit is being shifted, ser_clk rests at the edge-select value.
- R6: ser_store is high for exactly one cycle, immediately after the last bit period.
- R7: Bit 0 of offset 0x00 reads 1 from the first bit cycle through the strobe cycle, and reads 0 otherwise.
- R8: Requests that arrive during a transfer merge into a single pending transfer. That transfer begins one cycle after the strobe.
- R9: The output word, the masks, the hardware inputs and the edge select are captured when a transfer starts. Changing them during the transfer does not alter it.
- R10: The timer runs only when the source field [31:30] at offset 0x04 is 2'b10. Rate codes 0, 1, 2 and 3 give periods of BASE_DIV/2, /4, /8 and /10 cycles. Each expiry requests one transfer. Any other source value produces no timed transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dsl_in | input | 2 | Modem-core status for output bits 1:0 |
| phy1_in | input | 3 | First PHY status for output bits 4:2 |
| phy2_in | input | 3 | Second PHY status for output bits 7:5 |
| ser_clk | output | 1 | Shift clock to the cascade |
| ser_data | output | 1 | Serial data to the cascade |
| ser_store | output | 1 | One-cycle store strobe |

## Verification
The assertions check the following every cycle:
- the idle levels of the serial lines;
- that the strobe lasts one cycle, is marked busy, and is followed by an idle cycle;
- that a software request made while idle with groups enabled starts a transfer at once;
- that no transfer starts while all groups are disabled.

The bit order, the per-bit merge of hardware and software sources, and the clock phase for each edge setting need a reference model, which the bench compares on every clock. The same holds for capture at the start of a transfer, the merging of requests into one pending transfer, and the timer periods for each rate code.

// File: rtl/sro_pkg.sv
`timescale 1ns/1ps
package sro_pkg;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CFG  = 'h04;
  localparam int OFS_DATA = 'h08;
  localparam int B_UPD    = 31;
  localparam int HW_BITS  = 8;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_STORE} sh_state_e;

  typedef struct packed {
    logic [2:0] phy2_own;
    logic [2:0] phy1_own;
    logic [1:0] dsl_own;
    logic       edge_fall;
  } own_cfg_t;
endpackage

// File: rtl/sro_regs.sv
`timescale 1ns/1ps
module sro_regs import sro_pkg::*; #(
  parameter int GRP_N  = 3,
  parameter int GRP_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic                   busy,
  output own_cfg_t               own,
  output logic [GRP_N-1:0]       grp_en,
  output logic [1:0]             tsrc,
  output logic [1:0]             trate,
  output logic [GRP_N*GRP_W-1:0] data_q,
  output logic                   sw_req
);
  localparam int DW = GRP_N * GRP_W;

  logic hit_ctrl, hit_cfg, hit_data;
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_cfg  = (addr == ADDR_W'(OFS_CFG));
  assign hit_data = (addr == ADDR_W'(OFS_DATA));
  assign sw_req   = wr && hit_ctrl && wdata[B_UPD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own    <= '0;
      grp_en <= '0;
      tsrc   <= '0;
      trate  <= '0;
      data_q <= '0;
    end else if (wr) begin
      if (hit_ctrl)
        own <= '{phy2_own: wdata[17:15], phy1_own: wdata[29:27],
                 dsl_own: wdata[25:24], edge_fall: wdata[26]};
      if (hit_cfg) begin
        tsrc   <= wdata[31:30];
        trate  <= wdata[24:23];
        grp_en <= wdata[GRP_N-1:0];
      end
      if (hit_data) data_q <= wdata[DW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[29:27] = own.phy1_own;
      rdata[26]    = own.edge_fall;
      rdata[25:24] = own.dsl_own;
      rdata[17:15] = own.phy2_own;
      rdata[0]     = busy;
    end else if (hit_cfg) begin
      rdata[31:30]      = tsrc;
      rdata[24:23]      = trate;
      rdata[GRP_N-1:0]  = grp_en;
    end else if (hit_data) begin
      rdata[DW-1:0] = data_q;
    end
  end
endmodule

// File: rtl/sro_timer.sv
`timescale 1ns/1ps
module sro_timer #(
  parameter int BASE_DIV = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int LIM0 = BASE_DIV / 2;
  localparam int LIM1 = BASE_DIV / 4;
  localparam int LIM2 = BASE_DIV / 8;
  localparam int LIM3 = BASE_DIV / 10;
  localparam int CW   = $clog2(LIM0 + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          run;

  assign run = (src == 2'b10);

  always_comb begin
    case (rate)
      2'd0:    lim = CW'(LIM0);
      2'd1:    lim = CW'(LIM1);
      2'd2:    lim = CW'(LIM2);
      default: lim = CW'(LIM3);
    endcase
  end

  assign tick = run && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sro_shifter.sv
`timescale 1ns/1ps
module sro_shifter import sro_pkg::*; #(
  parameter int GRP_N = 3,
  parameter int GRP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [GRP_N*GRP_W-1:0] word,
  input  logic [GRP_N-1:0]       grp_en,
  input  logic                   edge_sel,
  output logic                   busy,
  output logic                   sck,
  output logic                   sdo,
  output logic                   stb
);
  localparam int DW = GRP_N * GRP_W;
  localparam int IW = $clog2(DW + 1);

  sh_state_e     st_q;
  logic [DW-1:0] word_q;
  logic [IW-1:0] idx_q, nbits;
  logic [1:0]    ph_q;
  logic          edge_q, pend_q, go;

  always_comb begin
    nbits = '0;
    for (int g = 0; g < GRP_N; g++)
      if (grp_en[g]) nbits = IW'((g + 1) * GRP_W);
  end

  assign go = req | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      word_q <= '0;
      idx_q  <= '0;
      ph_q   <= '0;
      edge_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      case (st_q)
        SH_IDLE: begin
          pend_q <= 1'b0;
          if (go && nbits != '0) begin
            st_q   <= SH_SHIFT;
            word_q <= word;
            idx_q  <= nbits - IW'(1);
            ph_q   <= '0;
            edge_q <= edge_sel;
          end
        end
        SH_SHIFT: begin
          if (req) pend_q <= 1'b1;
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) begin
            if (idx_q == '0) st_q  <= SH_STORE;
            else             idx_q <= idx_q - IW'(1);
          end
        end
        default: begin
          if (req) pend_q <= 1'b1;
          st_q <= SH_IDLE;
        end
      endcase
    end
  end

  assign busy = (st_q != SH_IDLE);
  assign stb  = (st_q == SH_STORE);
  assign sck  = (st_q == SH_SHIFT) ? (ph_q[1] ^ edge_q) : edge_sel;
  assign sdo  = (st_q == SH_SHIFT) && word_q[idx_q];
endmodule

// File: rtl/sro_ctrl.sv
`timescale 1ns/1ps
module sro_ctrl import sro_pkg::*; #(
  parameter int GRP_N    = 3,
  parameter int GRP_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int BASE_DIV = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        dsl_in,
  input  logic [2:0]        phy1_in,
  input  logic [2:0]        phy2_in,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_store
);
  localparam int DW = GRP_N * GRP_W;

  own_cfg_t             own;
  logic [GRP_N-1:0]     grp_en;
  logic [1:0]           tsrc, trate;
  logic [DW-1:0]        data_q, word;
  logic                 sw_req, tick, busy, edge_sel;
  logic [HW_BITS-1:0]   own_m, hw_v;

  sro_regs #(.GRP_N(GRP_N), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .busy(busy), .own(own), .grp_en(grp_en), .tsrc(tsrc),
    .trate(trate), .data_q(data_q), .sw_req(sw_req)
  );

  sro_timer #(.BASE_DIV(BASE_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .src(tsrc), .rate(trate), .tick(tick)
  );

  assign own_m    = {own.phy2_own, own.phy1_own, own.dsl_own};
  assign hw_v     = {phy2_in, phy1_in, dsl_in};
  assign edge_sel = own.edge_fall;

  for (genvar b = 0; b < DW; b++) begin : g_mrg
    if (b < HW_BITS) begin : g_hw
      assign word[b] = own_m[b] ? hw_v[b] : data_q[b];
    end else begin : g_sw
      assign word[b] = data_q[b];
    end
  end

  sro_shifter #(.GRP_N(GRP_N), .GRP_W(GRP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .req(sw_req | tick), .word(word), .grp_en(grp_en),
    .edge_sel(edge_sel), .busy(busy), .sck(ser_clk), .sdo(ser_data), .stb(ser_store)
  );
endmodule

// File: rtl/sro_chk.sv
`timescale 1ns/1ps
module sro_chk #(
  parameter int GRP_N  = 3,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy,
  input logic              edge_sel,
  input logic [GRP_N-1:0]  grp_en,
  input logic              ser_clk,
  input logic              ser_data,
  input logic              ser_store
);
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_store |=> !ser_store); // R6
  AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ser_store |-> busy); // R7
  AST_IDLE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_store |=> !busy); // R8
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_data && ser_clk == edge_sel)); // R5
  AST_NO_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en == '0 && !busy) |=> !busy); // R3
  AST_START_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[31] && !busy && grp_en != '0) |=> busy); // R4
endmodule

bind sro_ctrl sro_chk #(.GRP_N(GRP_N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .edge_sel(edge_sel), .grp_en(grp_en),
  .ser_clk(ser_clk), .ser_data(ser_data), .ser_store(ser_store)
);

// File: tb/sim_sro_ctrl.sv
`timescale 1ns/1ps
module sim_sro_ctrl;
  localparam int BASE = 400;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  dsl_in = '0;
  logic [2:0]  phy1_in = '0, phy2_in = '0;
  logic        ser_clk, ser_data, ser_store;

  int n_chk = 0, n_bad = 0, n_stb = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  sro_ctrl #(.BASE_DIV(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsl_in(dsl_in),
    .phy1_in(phy1_in), .phy2_in(phy2_in), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_store(ser_store)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  int m_st = 0, m_cnt = 0, m_n = 0, m_tcnt = 0;
  bit m_pend = 0, m_edge = 0;
  bit m_q[$];
  logic [31:0] m_ctrl = '0, m_cfg = '0, m_data = '0;

  function automatic int lim_of(input logic [1:0] r);
    case (r)
      2'd0: return BASE / 2;
      2'd1: return BASE / 4;
      2'd2: return BASE / 8;
      default: return BASE / 10;
    endcase
  endfunction

  function automatic bit src_bit(input int b);
    if (b < 2)      return m_ctrl[24+b] ? dsl_in[b]    : m_data[b];
    else if (b < 5) return m_ctrl[25+b] ? phy1_in[b-2] : m_data[b];
    else if (b < 8) return m_ctrl[10+b] ? phy2_in[b-5] : m_data[b];
    return m_data[b];
  endfunction

  always @(posedge clk) begin
    bit sw, tk, rq;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_n = 0; m_tcnt = 0; m_pend = 0; m_edge = 0;
      m_q.delete(); m_ctrl = '0; m_cfg = '0; m_data = '0;
    end else begin
      sw = bus_wr && bus_addr == 5'h00 && bus_wdata[31];
      tk = (m_cfg[31:30] == 2'b10) && (m_tcnt >= lim_of(m_cfg[24:23]) - 1);
      if (m_cfg[31:30] != 2'b10 || tk) m_tcnt = 0; else m_tcnt++;
      rq = sw || tk;
      if (m_st == 0) begin
        if (rq || m_pend) begin
          m_pend = 0;
          m_n = 0;
          for (int g = 0; g < 3; g++) if (m_cfg[g]) m_n = 8 * (g + 1);
          if (m_n > 0) begin
            m_q.delete();
            for (int k = m_n - 1; k >= 0; k--) m_q.push_back(src_bit(k));
            m_st = 1; m_cnt = 0; m_edge = m_ctrl[26];
          end
        end
      end else if (m_st == 1) begin
        if (rq) m_pend = 1;
        m_cnt++;
        if (m_cnt == 4 * m_n) m_st = 2;
      end else begin
        if (rq) m_pend = 1;
        m_st = 0;
      end
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_ctrl = bus_wdata & 32'h3F03_8000;
          5'h04: m_cfg  = bus_wdata & 32'hC180_0007;
          5'h08: m_data = bus_wdata & 32'h00FF_FFFF;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    bit e_sd, e_sc;
    if (ser_store) n_stb++;
    if (cmp_on && !done) begin
      e_sd = (m_st == 1) ? m_q[m_cnt / 4] : 1'b0;
      e_sc = (m_st == 1) ? (((m_cnt % 4) >= 2) ^ m_edge) : m_ctrl[26];
      check(ser_data === e_sd, "R4 ser_data", {31'd0, ser_data}, {31'd0, e_sd});
      check(ser_clk === e_sc, "R5 ser_clk", {31'd0, ser_clk}, {31'd0, e_sc});
      check(ser_store === (m_st == 2), "R6 ser_store", {31'd0, ser_store}, {31'd0, m_st == 2});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic wait_idle();
    while (m_st != 0 || m_pend) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(ser_clk === 1'b0 && ser_data === 1'b0 && ser_store === 1'b0, "R1 lines",
          {29'd0, ser_clk, ser_data, ser_store}, 32'd0);
    rd_chk(5'h00, 32'h0, "R1 ctrl");
    rd_chk(5'h04, 32'h0, "R1 cfg");
    rd_chk(5'h08, 32'h0, "R1 data");
    cmp_on = 1'b1;

    // R2 readback, R3 no groups means no transfer
    n_stb = 0;
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h3F03_8000, "R2 ctrl fields, update bit reads 0");
    repeat (10) @(negedge clk);
    check(n_stb == 0, "R3 no groups no strobe", n_stb, 0);
    rd_chk(5'h00, 32'h3F03_8000, "R3 not busy");
    wr(5'h08, 32'hFFFF_FFFF);
    rd_chk(5'h08, 32'h00FF_FFFF, "R2 data");
    rd_chk(5'h0C, 32'h0, "R2 0x0C");
    rd_chk(5'h10, 32'h0, "R2 0x10");
    wr(5'h04, 32'hFFFF_FFFF);
    rd_chk(5'h04, 32'hC180_0007, "R2 cfg");
    wr(5'h04, 32'h0);
    wr(5'h00, 32'h0);
    wait_idle();

    // R4/R5/R6: 8 bits, rising capture
    wr(5'h04, 32'h1);
    wr(5'h08, 32'hA5);
    n_stb = 0;
    wr(5'h00, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd_chk(5'h00, 32'h1, "R7 busy during shift");
    wait_idle();
    check(n_stb == 1, "R6 one strobe", n_stb, 1);
    rd_chk(5'h00, 32'h0, "R7 busy clear");

    // R3: 16 and 24 bit lengths
    wr(5'h08, 32'h5A3C96);
    wr(5'h04, 32'h2);
    wr(5'h00, 32'h8000_0000);
    wait_idle();
    wr(5'h04, 32'h5);
    wr(5'h00, 32'h8000_0000);
    wait_idle();

    // R5: falling capture
    wr(5'h00, 32'h0400_0000);
    rd_chk(5'h00, 32'h0400_0000, "R5 edge bit");
    wr(5'h00, 32'h8400_0000);
    wait_idle();

    // R4: hardware ownership merge, full and partial masks
    dsl_in = 2'b10; phy1_in = 3'b101; phy2_in = 3'b011;
    wr(5'h04, 32'h1);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'hBB03_8000);
    wait_idle();
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h9100_8000);
    wait_idle();

    // R8: requests during a transfer merge into one pending transfer
    n_stb = 0;
    wr(5'h00, 32'h8000_0000);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'h8000_0000);
    wr(5'h00, 32'h8000_0000);
    wait_idle();
    check(n_stb == 2, "R8 merged pending", n_stb, 2);

    // R9: changes during a transfer do not alter it
    wr(5'h04, 32'h4);
    wr(5'h08, 32'h123456);
    wr(5'h00, 32'h8000_0000);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'hFEDCBA);
    wr(5'h00, 32'h3F03_8000);
    phy1_in = 3'b010;
    wait_idle();
    wr(5'h00, 32'h0);
    wait_idle();

    // R10: timer rates and sources
    wr(5'h04, 32'h1);
    wr(5'h04, 32'h8000_0001);
    n_stb = 0;
    repeat (440) @(negedge clk);
    check(n_stb == 2, "R10 rate 0 period", n_stb, 2);
    wr(5'h04, 32'h1);
    wait_idle();
    wr(5'h04, 32'h8180_0001);
    n_stb = 0;
    repeat (230) @(negedge clk);
    check(n_stb == 4, "R10 rate 3 period", n_stb, 4);
    wr(5'h04, 32'h1);
    wait_idle();
    wr(5'h04, 32'h4180_0001);
    n_stb = 0;
    repeat (300) @(negedge clk);
    check(n_stb == 0, "R10 source 01 idle", n_stb, 0);
    wr(5'h04, 32'hC180_0001);
    n_stb = 0;
    repeat (300) @(negedge clk);
    check(n_stb == 0, "R10 source 11 idle", n_stb, 0);
    wr(5'h04, 32'h1);
    wait_idle();

    finish_run();
  end
endmodule